// File: doc/BRIEF.md
# Single-Wire Pulse-Width Slave Interface

This block is the slave end of a one-wire, open-drain, return-to-one serial bus. The wire idles high. Every bit starts with a falling edge, and the length of the low pulse that follows gives its value. A host opens each frame with a long low pulse (the break) followed by a high gap (the recovery). It then sends a command byte, least significant bit first. The low seven bits of the command select a register. The top bit selects the direction: 1 for a write, 0 for a read.

On a write, the block receives one more byte and presents it to a simple register-file port. On a read, it fetches a byte through the same port, waits a short turnaround time, and then drives the byte back onto the wire, least significant bit first, encoding each bit by the width of its low pulse.

When interrupt signalling is enabled and a condition is raised, the block becomes the bus master. It sends its own break and recovery, then the fixed command byte 0x80 with no data byte, and it repeats this message once per interrupt period for as long as the condition lasts. A line held low for a very long time resets the interface. All timing is counted in microseconds, derived from the system clock by a prescaler.

Top module: `swire_slave`

## Requirements
- R1: While reset is asserted, and after it is released with the wire idle, `line_drive_low`, `reg_wr_en` and `reg_rd_en` are all 0.
- R2: A frame starts only after a low pulse of at least BREAK_US (190) µs. A frame that follows a shorter low pulse causes no register access.
- R3: After the break, the wire must stay high for at least RECOV_US (40) µs before the first command bit falls. A command bit that falls sooner cancels the frame, and the frame causes no register access.
- R4: Each received bit is sampled SAMPLE_US (68) µs after its falling edge: low means 0 and high means 1. Bytes arrive LSB first. Command bits 0..6 form `reg_addr`. Command bit 7 equal to 1 means write and equal to 0 means read. The block does not drive the wire while it is receiving.
- R5: For a write, a data byte follows the command. `reg_wr_en` pulses once, with `reg_addr` and `reg_wr_data` holding the received values, during the last bit of that byte.
- R6: For a read, `reg_rd_en` pulses for one cycle with `reg_addr` valid. The read data is taken from `reg_rd_data` at least one cycle later, and the returned byte equals that data.
- R7: The first falling edge of a read response comes 190–950 µs after the end of the host's eighth command bit cycle (a 190 µs host cycle is assumed). Response bits go LSB first. A 1 is driven low for 32–50 µs and a 0 for 80–145 µs. Successive falling edges are 190–250 µs apart.
- R8: A low pulse of at least BREAK_US µs in the middle of a byte abandons the byte. The release that ends it counts as a new break, so the next command after a valid recovery is accepted.
- R9: A low of RESET_US µs resets the interface. The release that ends this low is not treated as a break, so bits sent without a fresh break cause no register access. A later properly framed write succeeds.
- R10: With `irq_en` and `irq_req` both 1 and the bus idle, the block drives a break of about 200 µs and a recovery of about 50 µs. It then sends the byte 0x80 using the response bit encoding, with no data byte and no register access.
- R11: The interrupt message repeats every IRQ_PERIOD_US µs, measured between break edges, while both inputs stay 1. No message is sent while `irq_en` or `irq_req` is 0.
- R12: `reg_wr_en` and `reg_rd_en` are single-cycle pulses and are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Sensed level of the bus wire (asynchronous) |
| line_drive_low | output | 1 | 1 pulls the wire low through the open-drain pad |
| irq_en | input | 1 | Enables interrupt message mastering |
| irq_req | input | 1 | Interrupt condition is present |
| reg_addr | output | 7 | Register address for read or write |
| reg_rd_en | output | 1 | One-cycle read request |
| reg_rd_data | input | 8 | Read data, valid from the cycle after `reg_rd_en` |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Write data |

## Verification
A bit counter or shift register that is off by one shows up at the register port in the same frame: the write strobe goes to the wrong address, carries the wrong data, or is missing altogether. A framing state that misses a break or recovery makes a whole frame disappear. A pulse generator or timer that is wrong shows up within one bit period as a response pulse of the wrong width, a bit cycle of the wrong length, or a response whose start falls outside the allowed turnaround window. Interrupt timing errors appear only after a full period, when the spacing between two mastered breaks is measured.

// File: rtl/swire_pkg.sv
`timescale 1ns/1ps
package swire_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;
  localparam int BIT_CW = $clog2(BYTE_W);
  localparam logic [BYTE_W-1:0] IRQ_CMD = 8'h80;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECOV,
    ST_RX_WAIT,
    ST_RX_SAMP,
    ST_RESP_WAIT,
    ST_TX,
    ST_LOCK
  } sw_state_t;
endpackage

// File: rtl/swire_us_tick.sv
`timescale 1ns/1ps
module swire_us_tick #(
  parameter int DIV = 200
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) tick <= 1'b0;
        else     tick <= 1'b1;
      end
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt  <= '0;
          tick <= 1'b0;
        end else begin
          tick <= 1'b0;
          if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/swire_line_sync.sv
`timescale 1ns/1ps
module swire_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic line_q,
  output logic fell,
  output logic rose
);
  logic [2:0] s;

  always_ff @(posedge clk) begin
    if (rst) s <= 3'b111;
    else     s <= {s[1:0], din};
  end

  assign line_q = s[1];
  assign fell   = s[2] & ~s[1];
  assign rose   = ~s[2] & s[1];
endmodule

// File: rtl/swire_pulse_tx.sv
`timescale 1ns/1ps
module swire_pulse_tx #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         start,
  input  logic [W-1:0] low_len,
  input  logic [W-1:0] period_len,
  output logic         drive_low,
  output logic         done
);
  logic [W-1:0] cnt, lowr, perr;
  logic         busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      lowr      <= '0;
      perr      <= '0;
      busy      <= 1'b0;
      drive_low <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt       <= '0;
        lowr      <= low_len;
        perr      <= period_len;
        busy      <= 1'b1;
        drive_low <= 1'b1;
      end else if (busy && tick) begin
        cnt <= cnt + 1'b1;
        if (cnt + 1'b1 >= lowr) drive_low <= 1'b0;
        if (cnt + 1'b1 >= perr) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    done |-> !drive_low); // R7
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !drive_low); // R7
endmodule

// File: rtl/swire_slave.sv
`timescale 1ns/1ps
module swire_slave
  import swire_pkg::*;
#(
  parameter int US_DIV        = 200,
  parameter int BREAK_US      = 190,
  parameter int RECOV_US      = 40,
  parameter int SAMPLE_US     = 68,
  parameter int RESP_US       = 330,
  parameter int ONE_US        = 40,
  parameter int ZERO_US       = 110,
  parameter int CYCLE_US      = 205,
  parameter int MBRK_US       = 200,
  parameter int MREC_US       = 50,
  parameter int RESET_US      = 2000000,
  parameter int IRQ_PERIOD_US = 1000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_in,
  output logic              line_drive_low,
  input  logic              irq_en,
  input  logic              irq_req,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_rd_en,
  input  logic [BYTE_W-1:0] reg_rd_data,
  output logic              reg_wr_en,
  output logic [BYTE_W-1:0] reg_wr_data
);
  localparam int TMAX = (RESET_US > IRQ_PERIOD_US) ? RESET_US : IRQ_PERIOD_US;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] T_BREAK   = TW'(BREAK_US);
  localparam logic [TW-1:0] T_RECOV   = TW'(RECOV_US);
  localparam logic [TW-1:0] T_SAMP_M1 = TW'(SAMPLE_US - 1);
  localparam logic [TW-1:0] T_RESP    = TW'(RESP_US);
  localparam logic [TW-1:0] T_ONE     = TW'(ONE_US);
  localparam logic [TW-1:0] T_ZERO    = TW'(ZERO_US);
  localparam logic [TW-1:0] T_CYCLE   = TW'(CYCLE_US);
  localparam logic [TW-1:0] T_MBRK    = TW'(MBRK_US);
  localparam logic [TW-1:0] T_MFRAME  = TW'(MBRK_US + MREC_US);
  localparam logic [TW-1:0] T_RESET   = TW'(RESET_US);
  localparam logic [TW-1:0] T_IRQ     = TW'(IRQ_PERIOD_US);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

  logic tick, line_q, fell, rose, tx_done;
  sw_state_t           state;
  logic [TW-1:0]       tmr, low_us, irq_tmr;
  logic [BIT_CW-1:0]   bit_cnt;
  logic [BYTE_W-2:0]   sr;
  logic [BYTE_W-1:0]   sh, nb;
  logic                data_phase, tx_break, tx_start;
  logic [TW-1:0]       tx_low, tx_per;
  logic                irq_due, irq_fire, frame_ok;

  swire_us_tick #(.DIV(US_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  swire_line_sync u_sync (
    .clk(clk), .rst(rst), .din(line_in),
    .line_q(line_q), .fell(fell), .rose(rose)
  );

  swire_pulse_tx #(.W(TW)) u_ptx (
    .clk(clk), .rst(rst), .tick(tick), .start(tx_start),
    .low_len(tx_low), .period_len(tx_per),
    .drive_low(line_drive_low), .done(tx_done)
  );

  // length of the current low phase in microseconds, saturating
  always_ff @(posedge clk) begin
    if (rst || line_q)                   low_us <= '0;
    else if (tick && low_us != T_RESET)  low_us <= low_us + 1'b1;
  end

  assign irq_due  = (irq_tmr == T_IRQ);
  assign irq_fire = (state == ST_IDLE) && irq_en && irq_req && irq_due && line_q && !rose;
  assign frame_ok = (state != ST_TX) && (state != ST_LOCK);
  assign nb       = {line_q, sr};

  always_ff @(posedge clk) begin
    if (rst)                             irq_tmr <= T_IRQ;
    else if (irq_fire)                   irq_tmr <= '0;
    else if (tick && irq_tmr != T_IRQ)   irq_tmr <= irq_tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      tmr         <= '0;
      bit_cnt     <= '0;
      sr          <= '0;
      sh          <= '0;
      data_phase  <= 1'b0;
      tx_break    <= 1'b0;
      tx_start    <= 1'b0;
      tx_low      <= '0;
      tx_per      <= '0;
      reg_addr    <= '0;
      reg_wr_en   <= 1'b0;
      reg_wr_data <= '0;
      reg_rd_en   <= 1'b0;
    end else begin
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      tx_start  <= 1'b0;
      if (frame_ok && !line_q && low_us == T_RESET) begin
        state <= ST_LOCK;
      end else if (frame_ok && rose && low_us >= T_BREAK) begin
        state      <= ST_RECOV;
        tmr        <= '0;
        bit_cnt    <= '0;
        data_phase <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: if (irq_fire) begin
            state    <= ST_TX;
            tx_break <= 1'b1;
            sh       <= IRQ_CMD;
            bit_cnt  <= '0;
            tx_low   <= T_MBRK;
            tx_per   <= T_MFRAME;
            tx_start <= 1'b1;
          end
          ST_RECOV: begin
            if (tick && tmr < T_RECOV) tmr <= tmr + 1'b1;
            if (fell) begin
              tmr   <= '0;
              state <= (tmr >= T_RECOV) ? ST_RX_SAMP : ST_IDLE;
            end
          end
          ST_RX_WAIT: if (fell) begin
            tmr   <= '0;
            state <= ST_RX_SAMP;
          end
          ST_RX_SAMP: if (tick) begin
            if (tmr == T_SAMP_M1) begin
              tmr     <= '0;
              sr      <= nb[BYTE_W-1:1];
              bit_cnt <= bit_cnt + 1'b1;
              state   <= ST_RX_WAIT;
              if (bit_cnt == LAST_BIT) begin
                if (data_phase) begin
                  reg_wr_en   <= 1'b1;
                  reg_wr_data <= nb;
                  state       <= ST_IDLE;
                end else begin
                  reg_addr <= nb[ADDR_W-1:0];
                  if (nb[BYTE_W-1]) begin
                    data_phase <= 1'b1;
                  end else begin
                    reg_rd_en <= 1'b1;
                    state     <= ST_RESP_WAIT;
                  end
                end
              end
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_RESP_WAIT: if (tick) begin
            if (tmr == T_RESP) begin
              sh       <= reg_rd_data >> 1;
              tx_low   <= reg_rd_data[0] ? T_ONE : T_ZERO;
              tx_per   <= T_CYCLE;
              tx_start <= 1'b1;
              tx_break <= 1'b0;
              bit_cnt  <= '0;
              state    <= ST_TX;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_TX: if (tx_done) begin
            if (!tx_break && bit_cnt == LAST_BIT) begin
              state <= ST_IDLE;
            end else begin
              if (!tx_break) bit_cnt <= bit_cnt + 1'b1;
              tx_break <= 1'b0;
              sh       <= sh >> 1;
              tx_low   <= sh[0] ? T_ONE : T_ZERO;
              tx_per   <= T_CYCLE;
              tx_start <= 1'b1;
            end
          end
          ST_LOCK: if (line_q) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd_en && reg_wr_en)); // R12
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en); // R12
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |=> !reg_rd_en); // R6
  AST_RD_THEN_WAIT: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |-> (state == ST_RESP_WAIT)); // R6
  AST_RX_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RX_WAIT || state == ST_RX_SAMP) |-> !line_drive_low); // R4
  AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK) |-> !line_drive_low); // R9
endmodule

// File: tb/swire_slave_bench.sv
`timescale 1ns/1ps
module swire_slave_bench;
  localparam int US_DIV   = 1;
  localparam int RESET_US = 3000;
  localparam int IRQ_US   = 2500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       host_low = 1'b0;
  logic       drv, line;
  logic       irq_en = 1'b0, irq_req = 1'b0;
  logic [6:0] reg_addr;
  logic       reg_rd_en, reg_wr_en;
  logic [7:0] reg_rd_data, reg_wr_data;

  assign line = ~(host_low | drv);

  swire_slave #(.US_DIV(US_DIV), .RESET_US(RESET_US), .IRQ_PERIOD_US(IRQ_US)) u_swire_slave (
    .clk(clk), .rst(rst), .line_in(line), .line_drive_low(drv),
    .irq_en(irq_en), .irq_req(irq_req), .reg_addr(reg_addr),
    .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data)
  );

  function automatic logic [7:0] exp_rd(input logic [6:0] a);
    return 8'((int'(a) * 37 + 11) & 255);
  endfunction

  int checks = 0, errors = 0, wr_cnt = 0, rd_cnt = 0, cyc = 0, dut_falls = 0;
  logic [6:0] wr_a = '0;
  logic [7:0] wr_d = '0;
  logic       line_prev = 1'b1;
  bit         finished = 1'b0;

  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    if (reg_rd_en) begin
      reg_rd_data <= exp_rd(reg_addr);
      rd_cnt      <= rd_cnt + 1;
    end
    if (reg_wr_en) begin
      wr_cnt <= wr_cnt + 1;
      wr_a   <= reg_addr;
      wr_d   <= reg_wr_data;
    end
  end

  always @(negedge clk) begin
    if (line_prev && !line && !host_low) dut_falls = dut_falls + 1;
    line_prev = line;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (n * US_DIV) @(negedge clk);
  endtask

  task automatic host_bit(input logic b);
    host_low = 1'b1;
    wait_us(b ? 10 : 110);
    host_low = 1'b0;
    wait_us(b ? 180 : 80);
  endtask

  task automatic host_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) host_bit(v[i]);
  endtask

  task automatic host_break(input int lo, input int rec);
    host_low = 1'b1;
    wait_us(lo);
    host_low = 1'b0;
    wait_us(rec);
  endtask

  task automatic host_write(input logic [6:0] a, input logic [7:0] d);
    host_break(200, 50);
    host_byte({1'b1, a});
    host_byte(d);
    wait_us(10);
  endtask

  // entered with the wire just seen low at the start of bit 0
  task automatic rx_byte(output logic [7:0] v, output int bad);
    v = '0;
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      int lo, hi;
      lo = 0;
      hi = 0;
      while (!line && lo < 1000) begin @(negedge clk); lo++; end
      if (i < 7) while (line && hi < 1000) begin @(negedge clk); hi++; end
      lo = lo / US_DIV;
      hi = hi / US_DIV;
      v[i] = (lo < 65);
      if (lo < 65) begin
        if (lo < 32 || lo > 50) bad++;
      end else if (lo < 80 || lo > 145) bad++;
      if (i < 7 && (lo + hi < 190 || lo + hi > 250)) bad++;
    end
  endtask

  task automatic host_read(input logic [6:0] a, output logic [7:0] v,
                           output int dly, output int bad);
    int c;
    host_break(200, 50);
    host_byte({1'b0, a});
    c = 0;
    while (line && c < 2000 * US_DIV) begin @(negedge clk); c++; end
    dly = c / US_DIV;
    rx_byte(v, bad);
    wait_us(150);
  endtask

  task automatic recv_irq(output int t, output logic [7:0] v, output int blo,
                          output int bhi, output int bad);
    int c;
    c = 0;
    while (line && c < 3 * IRQ_US * US_DIV) begin @(negedge clk); c++; end
    t = cyc;
    blo = 0;
    bhi = 0;
    while (!line && blo < 1000) begin @(negedge clk); blo++; end
    while (line && bhi < 1000) begin @(negedge clk); bhi++; end
    blo = blo / US_DIV;
    bhi = bhi / US_DIV;
    rx_byte(v, bad);
    wait_us(150);
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    int w0, r0, f0, dly, bad, t1, t2, blo, bhi;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    chk(drv == 1'b0, "R1 drive in reset", int'(drv), 0);
    chk(!reg_wr_en && !reg_rd_en, "R1 strobes in reset", int'(reg_wr_en) + int'(reg_rd_en), 0);
    rst = 1'b0;
    wait_us(20);
    chk(drv == 1'b0 && wr_cnt == 0 && rd_cnt == 0, "R1 idle after reset",
        int'(drv) + wr_cnt + rd_cnt, 0);

    // writes over several addresses and data patterns, including the top address
    for (int k = 0; k < 6; k++) begin
      logic [6:0] a;
      logic [7:0] d;
      a = (k == 5) ? 7'h7F : 7'(k * 41);
      d = (k == 5) ? 8'hFF : 8'(k * 67 + 1);
      w0 = wr_cnt;
      host_write(a, d);
      chk(wr_cnt == w0 + 1, "R5 one write strobe", wr_cnt - w0, 1);
      chk(wr_a == a, "R4 write address", int'(wr_a), int'(a));
      chk(wr_d == d, "R5 write data", int'(wr_d), int'(d));
    end

    // reads, response data and bit timing
    for (int k = 0; k < 6; k++) begin
      logic [6:0] a;
      a = (k == 5) ? 7'h00 : 7'(k * 29 + 127);
      w0 = wr_cnt;
      r0 = rd_cnt;
      host_read(a, v, dly, bad);
      chk(v == exp_rd(a), "R6 read data", int'(v), int'(exp_rd(a)));
      chk(rd_cnt == r0 + 1, "R6 one read strobe", rd_cnt - r0, 1);
      chk(wr_cnt == w0, "R4 read bit makes no write", wr_cnt - w0, 0);
      chk(dly >= 190 && dly <= 950, "R7 turnaround", dly, 208);
      chk(bad == 0, "R7 pulse widths and cycles", bad, 0);
    end

    // low pulse shorter than a break
    w0 = wr_cnt;
    host_break(150, 50);
    host_byte({1'b1, 7'h11});
    host_byte(8'h22);
    wait_us(10);
    chk(wr_cnt == w0, "R2 short break ignored", wr_cnt - w0, 0);

    // recovery too short
    host_break(200, 20);
    host_byte({1'b1, 7'h12});
    host_byte(8'h23);
    wait_us(10);
    chk(wr_cnt == w0, "R3 short recovery ignored", wr_cnt - w0, 0);

    // break in mid-byte resynchronises
    host_break(200, 50);
    host_bit(1'b1);
    host_bit(1'b0);
    host_bit(1'b1);
    host_break(200, 50);
    host_byte({1'b1, 7'h55});
    host_byte(8'h3C);
    wait_us(10);
    chk(wr_cnt == w0 + 1, "R8 single write after abort", wr_cnt - w0, 1);
    chk(wr_a == 7'h55 && wr_d == 8'h3C, "R8 write after abort",
        int'({wr_a, wr_d}), int'({7'h55, 8'h3C}));

    // long low resets, release is no break
    w0 = wr_cnt;
    host_break(RESET_US + 50, 50);
    host_byte({1'b1, 7'h2A});
    host_byte(8'h5A);
    wait_us(10);
    chk(wr_cnt == w0, "R9 no frame after line reset", wr_cnt - w0, 0);
    host_write(7'h2A, 8'h5A);
    chk(wr_cnt == w0 + 1 && wr_a == 7'h2A && wr_d == 8'h5A, "R9 framed write after reset",
        wr_cnt - w0, 1);

    // interrupt mastering
    irq_req = 1'b1;
    f0 = dut_falls;
    wait_us(IRQ_US + 500);
    chk(dut_falls == f0, "R11 silent while disabled", dut_falls - f0, 0);
    w0 = wr_cnt;
    r0 = rd_cnt;
    irq_en = 1'b1;
    recv_irq(t1, v, blo, bhi, bad);
    chk(v == 8'h80, "R10 message byte", int'(v), 128);
    chk(blo >= 190 && blo <= 210, "R10 mastered break", blo, 200);
    chk(bhi >= 40 && bhi <= 60, "R10 mastered recovery", bhi, 50);
    chk(bad == 0, "R10 message bit timing", bad, 0);
    recv_irq(t2, v, blo, bhi, bad);
    chk(v == 8'h80, "R11 repeated message", int'(v), 128);
    chk((t2 - t1) / US_DIV >= IRQ_US - 2 && (t2 - t1) / US_DIV <= IRQ_US + 5,
        "R11 repeat period", (t2 - t1) / US_DIV, IRQ_US);
    chk(wr_cnt == w0 && rd_cnt == r0, "R10 no register access",
        (wr_cnt - w0) + (rd_cnt - r0), 0);
    irq_req = 1'b0;
    f0 = dut_falls;
    wait_us(IRQ_US + 500);
    chk(dut_falls == f0, "R11 silent without request", dut_falls - f0, 0);

    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      report();
      $finish;
    end
  end
endmodule